// File: doc/BRIEF.md
# Cache Data ECC Error Logger

This block sits beside a cache data array in which every 128-bit octoword carries a 10-bit single-correct/double-detect check code. A half cacheline is four octowords, read as four lanes in one beat. For each beat, the decoder reports which lanes saw a corrected single-bit error and which saw an uncorrectable double-bit error. With each beat it also gives the ten-bit syndrome of every lane, the data-store index and the set number.

The logger keeps one sticky flag for each error class and captures the location and syndromes of the first error. A later double-bit error may replace a logged single-bit capture, but nothing replaces a logged double-bit capture. Each class raises a maskable interrupt. A small register port sets the enables, clears the flags (write one to clear) and reads back the captured state. Software can also use a diagnostic mode: with checking turned off, a load from the diagnostic requester latches the raw check bits of one chosen half cacheline into the syndrome fields.

Top module: `ecc_err_log`

## Requirements
- R1: While the checking enable (control bit 0) is 0, reports set no flag and capture nothing.
- R2: A beat with `rpt_valid` high and any `rpt_sec` lane set sets the single-error flag. Any `rpt_ded` lane set sets the double-error flag. Both flags stay set until they are cleared.
- R3: A capture stores the index in word 1 bits [IDX_W-1:0], the set number directly above it, and the lane mask (lanes with either error) above the set. It stores the lane 0/1 syndromes in word 2 (lane 0 in the low half) and the lane 2/3 syndromes in word 3.
- R4: A double-bit error always overwrites a logged single-bit capture. A beat that holds both kinds is captured as a double-bit error.
- R5: While the single-error flag is set, a later single-bit error does not change the captured fields.
- R6: While the double-error flag is set, no error changes the captured fields.
- R7: Writing word 0 with bit 4 or bit 5 set clears the single or double flag. An error in the same cycle wins: it sets the flag and is captured. Once both flags are clear, capture is armed again.
- R8: Control word 0 holds checking enable (bit 0), single-error interrupt enable (bit 1), double-error interrupt enable (bit 2) and half select (bit 3). A read of word 0 returns these bits with the single flag at bit 4 and the double flag at bit 5. `reg_rdata` shows the word addressed in the previous cycle.
- R9: Each interrupt output is high exactly when its flag and its enable were both set in the previous cycle.
- R10: With checking off and `diag_mode` high, a `diag_load` beat whose `diag_half` equals the half select copies the four lanes of `diag_chk` into the syndrome fields. Address fields and flags are left unchanged.
- R11: A diagnostic beat does nothing if the half does not match, if `diag_mode` is low, or if checking is on.
- R12: After reset, all four words read as zero and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | Decoder report beat valid |
| rpt_sec | input | 4 | Per-lane corrected single-error indication |
| rpt_ded | input | 4 | Per-lane double-error indication |
| rpt_syn | input | 4*SYN_W | Per-lane syndromes, lane 0 in the low bits |
| rpt_idx | input | IDX_W | Data-store index of the beat |
| rpt_set | input | SET_W | Set number of the beat |
| diag_mode | input | 1 | Diagnostic latch mode |
| diag_load | input | 1 | Load beat from the diagnostic requester |
| diag_half | input | 1 | Half of the line on this load (0 first four octowords, 1 last four) |
| diag_chk | input | 4*SYN_W | Raw per-lane check bits, lane 0 in the low bits |
| reg_wr | input | 1 | Write strobe for control word 0 |
| reg_addr | input | 2 | Word select for writes and reads |
| reg_wdata | input | 6 | Write data for word 0 |
| reg_rdata | output | 2*SYN_W | Registered read data |
| irq_sec | output | 1 | Single-error interrupt |
| irq_ded | output | 1 | Double-error interrupt |

## Verification
The assertions assume that the decoder asserts a lane's error bits only on beats with `rpt_valid` high. They also assume that the clear strobes and report beats are plain synchronous pulses. The bench drives every input on the falling edge and holds each report for exactly one cycle. It drops `rpt_valid` whenever no lane is in error. It writes control word 0 only through the register port, so clears always arrive as single-cycle pulses of the write strobe.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  localparam int LANES = 4;
  localparam int CTL_W = 6;

  localparam int B_ECC  = 0;
  localparam int B_SIE  = 1;
  localparam int B_DIE  = 2;
  localparam int B_HSEL = 3;
  localparam int B_CSEC = 4;
  localparam int B_CDED = 5;

  typedef enum logic [1:0] {
    RA_CTL    = 2'd0,
    RA_LOC    = 2'd1,
    RA_SYN_LO = 2'd2,
    RA_SYN_HI = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic half_sel;
    logic ded_ie;
    logic sec_ie;
    logic ecc_on;
  } ctl_t;

endpackage

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
  import ecc_log_pkg::*;
#(
  parameter int REG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CTL_W-1:0] reg_wdata,
  input  logic             sec_flag,
  input  logic             ded_flag,
  input  logic [REG_W-1:0] loc_word,
  input  logic [REG_W-1:0] syn_lo_word,
  input  logic [REG_W-1:0] syn_hi_word,
  output ctl_t             ctl,
  output logic             clr_sec,
  output logic             clr_ded,
  output logic [REG_W-1:0] reg_rdata
);

  logic ctl_wr;
  logic [REG_W-1:0] rd_mux;

  assign ctl_wr  = reg_wr && (reg_addr_e'(reg_addr) == RA_CTL);
  assign clr_sec = ctl_wr && reg_wdata[B_CSEC];
  assign clr_ded = ctl_wr && reg_wdata[B_CDED];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (ctl_wr) begin
      ctl.ecc_on   <= reg_wdata[B_ECC];
      ctl.sec_ie   <= reg_wdata[B_SIE];
      ctl.ded_ie   <= reg_wdata[B_DIE];
      ctl.half_sel <= reg_wdata[B_HSEL];
    end
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_CTL:    rd_mux = REG_W'({ded_flag, sec_flag, ctl.half_sel,
                                  ctl.ded_ie, ctl.sec_ie, ctl.ecc_on});
      RA_LOC:    rd_mux = loc_word;
      RA_SYN_LO: rd_mux = syn_lo_word;
      default:   rd_mux = syn_hi_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
  import ecc_log_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int SET_W = 3,
  parameter int SYN_W = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ecc_on,
  input  logic                         half_sel,
  input  logic                         rpt_valid,
  input  logic [LANES-1:0]             rpt_sec,
  input  logic [LANES-1:0]             rpt_ded,
  input  logic [LANES*SYN_W-1:0]       rpt_syn,
  input  logic [IDX_W-1:0]             rpt_idx,
  input  logic [SET_W-1:0]             rpt_set,
  input  logic                         diag_mode,
  input  logic                         diag_load,
  input  logic                         diag_half,
  input  logic [LANES*SYN_W-1:0]       diag_chk,
  input  logic                         clr_sec,
  input  logic                         clr_ded,
  output logic                         sec_flag,
  output logic                         ded_flag,
  output logic [IDX_W-1:0]             fail_idx,
  output logic [SET_W-1:0]             fail_set,
  output logic [LANES-1:0]             fail_mask,
  output logic [LANES-1:0][SYN_W-1:0]  syn_q
);

  logic sec_ev, ded_ev;
  logic sec_keep, ded_keep;
  logic cap_sec, cap_ded, cap;
  logic diag_hit;

  // Error events only count while checking is enabled.
  assign sec_ev = rpt_valid && ecc_on && (|rpt_sec);
  assign ded_ev = rpt_valid && ecc_on && (|rpt_ded);

  // Flag value after this cycle's clear pulse; gates capture.
  assign sec_keep = sec_flag && !clr_sec;
  assign ded_keep = ded_flag && !clr_ded;

  // Priority: a double error replaces a single capture; a held double
  // capture blocks everything; a held single capture blocks singles.
  assign cap_ded = ded_ev && !ded_keep;
  assign cap_sec = sec_ev && !ded_ev && !sec_keep && !ded_keep;
  assign cap     = cap_ded || cap_sec;

  assign diag_hit = !ecc_on && diag_mode && diag_load && (diag_half == half_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_flag <= 1'b0;
      ded_flag <= 1'b0;
    end else begin
      sec_flag <= sec_keep || sec_ev;
      ded_flag <= ded_keep || ded_ev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_idx  <= '0;
      fail_set  <= '0;
      fail_mask <= '0;
    end else if (cap) begin
      fail_idx  <= rpt_idx;
      fail_set  <= rpt_set;
      fail_mask <= rpt_sec | rpt_ded;
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [SYN_W-1:0] lane_syn;
    logic [SYN_W-1:0] lane_chk;
    assign lane_syn = rpt_syn[ln*SYN_W +: SYN_W];
    assign lane_chk = diag_chk[ln*SYN_W +: SYN_W];

    always_ff @(posedge clk) begin
      if (rst)           syn_q[ln] <= '0;
      else if (cap)      syn_q[ln] <= lane_syn;
      else if (diag_hit) syn_q[ln] <= lane_chk;
    end
  end

endmodule

// File: rtl/ecc_log_irq.sv
module ecc_log_irq (
  input  logic clk,
  input  logic rst,
  input  logic sec_flag,
  input  logic ded_flag,
  input  logic sec_ie,
  input  logic ded_ie,
  output logic irq_sec,
  output logic irq_ded
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_sec <= 1'b0;
      irq_ded <= 1'b0;
    end else begin
      irq_sec <= sec_flag && sec_ie;
      irq_ded <= ded_flag && ded_ie;
    end
  end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int SET_W = 3,
  parameter int SYN_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rpt_valid,
  input  logic [3:0]             rpt_sec,
  input  logic [3:0]             rpt_ded,
  input  logic [4*SYN_W-1:0]     rpt_syn,
  input  logic [IDX_W-1:0]       rpt_idx,
  input  logic [SET_W-1:0]       rpt_set,
  input  logic                   diag_mode,
  input  logic                   diag_load,
  input  logic                   diag_half,
  input  logic [4*SYN_W-1:0]     diag_chk,
  input  logic                   reg_wr,
  input  logic [1:0]             reg_addr,
  input  logic [5:0]             reg_wdata,
  output logic [2*SYN_W-1:0]     reg_rdata,
  output logic                   irq_sec,
  output logic                   irq_ded
);

  localparam int REG_W = 2 * SYN_W;

  ctl_t ctl;
  logic clr_sec, clr_ded;
  logic sec_flag, ded_flag;
  logic [IDX_W-1:0] fail_idx;
  logic [SET_W-1:0] fail_set;
  logic [LANES-1:0] fail_mask;
  logic [LANES-1:0][SYN_W-1:0] syn_q;
  logic [REG_W-1:0] loc_word, syn_lo_word, syn_hi_word;

  assign loc_word    = REG_W'({fail_mask, fail_set, fail_idx});
  assign syn_lo_word = {syn_q[1], syn_q[0]};
  assign syn_hi_word = {syn_q[3], syn_q[2]};

  ecc_log_regif #(.REG_W(REG_W)) u_regif (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .sec_flag    (sec_flag),
    .ded_flag    (ded_flag),
    .loc_word    (loc_word),
    .syn_lo_word (syn_lo_word),
    .syn_hi_word (syn_hi_word),
    .ctl         (ctl),
    .clr_sec     (clr_sec),
    .clr_ded     (clr_ded),
    .reg_rdata   (reg_rdata)
  );

  ecc_log_capture #(.IDX_W(IDX_W), .SET_W(SET_W), .SYN_W(SYN_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .ecc_on    (ctl.ecc_on),
    .half_sel  (ctl.half_sel),
    .rpt_valid (rpt_valid),
    .rpt_sec   (rpt_sec),
    .rpt_ded   (rpt_ded),
    .rpt_syn   (rpt_syn),
    .rpt_idx   (rpt_idx),
    .rpt_set   (rpt_set),
    .diag_mode (diag_mode),
    .diag_load (diag_load),
    .diag_half (diag_half),
    .diag_chk  (diag_chk),
    .clr_sec   (clr_sec),
    .clr_ded   (clr_ded),
    .sec_flag  (sec_flag),
    .ded_flag  (ded_flag),
    .fail_idx  (fail_idx),
    .fail_set  (fail_set),
    .fail_mask (fail_mask),
    .syn_q     (syn_q)
  );

  ecc_log_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .sec_flag (sec_flag),
    .ded_flag (ded_flag),
    .sec_ie   (ctl.sec_ie),
    .ded_ie   (ctl.ded_ie),
    .irq_sec  (irq_sec),
    .irq_ded  (irq_ded)
  );

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int IDX_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             rpt_valid,
  input logic [3:0]       rpt_ded,
  input logic             ecc_on,
  input logic             sec_ie,
  input logic             ded_ie,
  input logic             sec_flag,
  input logic             ded_flag,
  input logic             clr_sec,
  input logic             clr_ded,
  input logic [IDX_W-1:0] fail_idx,
  input logic             irq_sec,
  input logic             irq_ded
);

  logic ded_ev;
  assign ded_ev = rpt_valid && ecc_on && (|rpt_ded);

  assert_no_log_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    ($rose(sec_flag) || $rose(ded_flag)) |-> $past(ecc_on));

  assert_ded_has_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ded_flag) |-> $past(rpt_valid && (|rpt_ded)));

  assert_sec_capture_held_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(sec_flag) && !$past(clr_sec) && !$past(ded_ev)) |-> $stable(fail_idx));

  assert_ded_capture_held_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(ded_flag) && !$past(clr_ded)) |-> $stable(fail_idx));

  assert_irq_sec_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq_sec |-> $past(sec_flag && sec_ie));

  assert_irq_ded_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ded |-> $past(ded_flag && ded_ie));

endmodule

bind ecc_err_log ecc_err_log_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rpt_valid(rpt_valid),
  .rpt_ded  (rpt_ded),
  .ecc_on   (ctl.ecc_on),
  .sec_ie   (ctl.sec_ie),
  .ded_ie   (ctl.ded_ie),
  .sec_flag (sec_flag),
  .ded_flag (ded_flag),
  .clr_sec  (clr_sec),
  .clr_ded  (clr_ded),
  .fail_idx (fail_idx),
  .irq_sec  (irq_sec),
  .irq_ded  (irq_ded)
);

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 11;
  localparam int SET_W = 3;
  localparam int SYN_W = 10;
  localparam int RW = 2 * SYN_W;

  typedef struct packed {
    logic [1:0]       clr;
    logic [3:0]       sec;
    logic [3:0]       ded;
    logic [IDX_W-1:0] idx;
    logic [SET_W-1:0] set;
    logic [SYN_W-1:0] syn;
    logic [1:0]       e_flags;
    logic [IDX_W-1:0] e_idx;
    logic [SET_W-1:0] e_set;
    logic [3:0]       e_mask;
    logic [SYN_W-1:0] e_syn;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'h1, 4'h0, 11'h005, 3'd1, 10'h011, 2'b01, 11'h005, 3'd1, 4'h1, 10'h011},
    '{2'd0, 4'h4, 4'h0, 11'h0AA, 3'd2, 10'h022, 2'b01, 11'h005, 3'd1, 4'h1, 10'h011},
    '{2'd0, 4'h0, 4'h2, 11'h3FF, 3'd7, 10'h0F0, 2'b11, 11'h3FF, 3'd7, 4'h2, 10'h0F0},
    '{2'd0, 4'h0, 4'h8, 11'h123, 3'd3, 10'h055, 2'b11, 11'h3FF, 3'd7, 4'h2, 10'h0F0},
    '{2'd0, 4'h1, 4'h0, 11'h010, 3'd0, 10'h066, 2'b11, 11'h3FF, 3'd7, 4'h2, 10'h0F0},
    '{2'd2, 4'h0, 4'h0, 11'h000, 3'd0, 10'h000, 2'b01, 11'h3FF, 3'd7, 4'h2, 10'h0F0},
    '{2'd0, 4'h2, 4'h0, 11'h020, 3'd4, 10'h033, 2'b01, 11'h3FF, 3'd7, 4'h2, 10'h0F0},
    '{2'd0, 4'h0, 4'h1, 11'h040, 3'd5, 10'h044, 2'b11, 11'h040, 3'd5, 4'h1, 10'h044},
    '{2'd3, 4'h0, 4'h0, 11'h000, 3'd0, 10'h000, 2'b00, 11'h040, 3'd5, 4'h1, 10'h044},
    '{2'd0, 4'h9, 4'h6, 11'h7FF, 3'd6, 10'h100, 2'b11, 11'h7FF, 3'd6, 4'hF, 10'h100},
    '{2'd3, 4'h4, 4'h0, 11'h001, 3'd0, 10'h200, 2'b01, 11'h001, 3'd0, 4'h4, 10'h200},
    '{2'd1, 4'h0, 4'h0, 11'h000, 3'd0, 10'h000, 2'b00, 11'h001, 3'd0, 4'h4, 10'h200}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rpt_valid = 1'b0;
  logic [3:0] rpt_sec = '0, rpt_ded = '0;
  logic [4*SYN_W-1:0] rpt_syn = '0;
  logic [IDX_W-1:0] rpt_idx = '0;
  logic [SET_W-1:0] rpt_set = '0;
  logic diag_mode = 1'b0, diag_load = 1'b0, diag_half = 1'b0;
  logic [4*SYN_W-1:0] diag_chk = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [5:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic irq_sec, irq_ded;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_log #(.IDX_W(IDX_W), .SET_W(SET_W), .SYN_W(SYN_W)) dut (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_sec(rpt_sec),
    .rpt_ded(rpt_ded), .rpt_syn(rpt_syn), .rpt_idx(rpt_idx), .rpt_set(rpt_set),
    .diag_mode(diag_mode), .diag_load(diag_load), .diag_half(diag_half),
    .diag_chk(diag_chk), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_sec(irq_sec),
    .irq_ded(irq_ded)
  );

  function automatic logic [4*SYN_W-1:0] lanes_of(input logic [SYN_W-1:0] b);
    return {b + SYN_W'(3), b + SYN_W'(2), b + SYN_W'(1), b};
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] v);
    @(negedge clk) reg_addr = a;
    @(negedge clk) v = reg_rdata;
  endtask

  task automatic wr_ctl(input logic [5:0] w);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = w; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic send(input logic [3:0] s, input logic [3:0] d, input logic [IDX_W-1:0] ix,
                      input logic [SET_W-1:0] st, input logic [SYN_W-1:0] sy,
                      input logic [1:0] clr, input logic [5:0] ctlw);
    @(negedge clk) begin
      rpt_valid = (s | d) != 4'h0;
      rpt_sec = s; rpt_ded = d; rpt_idx = ix; rpt_set = st; rpt_syn = lanes_of(sy);
      if (clr != 2'b00) begin
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ctlw | {clr[1], clr[0], 4'b0000};
      end
    end
    @(negedge clk) begin
      rpt_valid = 1'b0; rpt_sec = '0; rpt_ded = '0; reg_wr = 1'b0;
    end
  endtask

  task automatic diag(input logic mode, input logic half, input logic [SYN_W-1:0] b);
    @(negedge clk) begin
      diag_mode = mode; diag_load = 1'b1; diag_half = half; diag_chk = lanes_of(b);
    end
    @(negedge clk) begin diag_load = 1'b0; diag_mode = 1'b0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] v;
    logic [5:0] ctlw;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R12 reset word", v, '0);
    end
    check("R12 irq_sec", RW'(irq_sec), '0);
    check("R12 irq_ded", RW'(irq_ded), '0);

    // R8 control readback: bits ecc=0, sec_ie=1, ded_ie=2, half=3
    ctlw = 6'b000111;
    wr_ctl(ctlw);
    rd(2'd0, v);
    check("R8 ctl readback", v, RW'(ctlw));

    // Vector walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].sec, VECS[i].ded, VECS[i].idx, VECS[i].set, VECS[i].syn, VECS[i].clr, ctlw);
      rd(2'd0, v);
      check($sformatf("R2/R7 flags vec%0d", i), v, RW'({VECS[i].e_flags, 4'b0111}));
      rd(2'd1, v);
      check($sformatf("R3/R4/R5/R6 location vec%0d", i), v,
            RW'({VECS[i].e_mask, VECS[i].e_set, VECS[i].e_idx}));
      rd(2'd2, v);
      check($sformatf("R3 syn lanes0/1 vec%0d", i), v,
            {VECS[i].e_syn + SYN_W'(1), VECS[i].e_syn});
      rd(2'd3, v);
      check($sformatf("R3 syn lanes2/3 vec%0d", i), v,
            {VECS[i].e_syn + SYN_W'(3), VECS[i].e_syn + SYN_W'(2)});
      check($sformatf("R9 irq_sec vec%0d", i), RW'(irq_sec), RW'(VECS[i].e_flags[0]));
      check($sformatf("R9 irq_ded vec%0d", i), RW'(irq_ded), RW'(VECS[i].e_flags[1]));
    end

    // R9 masked single-error interrupt, then unmask
    ctlw = 6'b000101;
    wr_ctl(ctlw);
    send(4'h2, 4'h0, 11'h0AB, 3'd2, 10'h0AB, 2'b00, ctlw);
    repeat (2) @(negedge clk);
    check("R9 masked irq_sec", RW'(irq_sec), '0);
    ctlw = 6'b000111;
    wr_ctl(ctlw);
    @(negedge clk);
    check("R9 unmasked irq_sec", RW'(irq_sec), RW'(1));
    wr_ctl(6'b110111);
    rd(2'd1, v);
    check("R3 location after masked event", v, RW'({4'h2, 3'd2, 11'h0AB}));

    // R1 checking off: no flag, no capture
    ctlw = 6'b000110;
    wr_ctl(ctlw);
    send(4'h1, 4'h8, 11'h555, 3'd5, 10'h155, 2'b00, ctlw);
    rd(2'd0, v);
    check("R1 no flags when off", v, RW'(6'b000110));
    rd(2'd1, v);
    check("R1 location unchanged", v, RW'({4'h2, 3'd2, 11'h0AB}));
    check("R1 no irq", RW'({irq_ded, irq_sec}), '0);

    // R10 / R11 diagnostic latch with half select = 1
    ctlw = 6'b001000;
    wr_ctl(ctlw);
    diag(1'b1, 1'b0, 10'h3A0);
    rd(2'd2, v);
    check("R11 half mismatch ignored", v, {10'h0AC, 10'h0AB});
    diag(1'b1, 1'b1, 10'h3A0);
    rd(2'd2, v);
    check("R10 diag lanes0/1", v, {10'h3A1, 10'h3A0});
    rd(2'd3, v);
    check("R10 diag lanes2/3", v, {10'h3A3, 10'h3A2});
    rd(2'd1, v);
    check("R10 location untouched", v, RW'({4'h2, 3'd2, 11'h0AB}));
    diag(1'b0, 1'b1, 10'h155);
    rd(2'd2, v);
    check("R11 diag_mode low ignored", v, {10'h3A1, 10'h3A0});
    wr_ctl(6'b001001);
    diag(1'b1, 1'b1, 10'h0C0);
    rd(2'd2, v);
    check("R11 checking on ignores diag", v, {10'h3A1, 10'h3A0});
    rd(2'd0, v);
    check("R10 flags untouched", v, RW'(6'b001001));
    wr_ctl(6'b000000);
    diag(1'b1, 1'b0, 10'h0C0);
    rd(2'd3, v);
    check("R10 first half select", v, {10'h0C3, 10'h0C2});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule